// File: doc/BRIEF.md
# Duplicated Register File with Parity Check and Fault Injection

This block is a 32-bit register file with two read operands and one write port. The storage is held as two full copies. The first copy feeds read operand A and the second copy feeds read operand B. Each copy can also serve the other operand as a fallback. Every stored word carries eight check bits. These bits are verified whenever an enabled read takes place. A word that fails its check is replaced on the output by the same address from the other copy, provided that copy's check bits are good. The failing location is then rewritten from the good copy one cycle later.

A 16-bit control and status word is read and written through a simple register port. It holds a check-disable flag, a fault-injection enable, an 8-bit check-bit mask, a copy-select flag, a 3-bit saturating count of detected errors, and a fixed 2-bit protection-type code. With fault injection enabled, the mask is XORed into the check bits on every write, and only one copy is written. This lets software plant mismatches deliberately and exercise the recovery path.

Top module: `prf_top`

## Requirements
- R1: After reset both copies hold zero with valid check bits, both read outputs give 0 with no flags, and the control word reads 16'h4000.
- R2: With fault injection off, a write updates both copies. An enabled read on either operand then returns the written word with neither flag set.
- R3: Check bit j is the XOR of the data bits whose index modulo 8 equals j. When injection (control bit 1) is on, the mask in control bits 10:3 is XORed into these bits before they are stored. A zero mask therefore stores valid check bits.
- R4: When injection is on and copy select (control bit 2) is 0, a write reaches only the operand-B copy. When copy select is 1, a write reaches only the operand-A copy. When injection is off, copy select has no effect.
- R5: If an enabled read finds bad check bits in its own copy and good ones in the other copy, it returns the other copy's word and raises that operand's corrected flag. In the next cycle the bad location is rewritten with that word and valid check bits, unless a user write to the same copy occurs in that cycle.
- R6: If both copies fail the check at the address read, the operand returns its own copy's word and raises its uncorrectable flag, not its corrected flag.
- R7: Each enabled read with a detected error, whether corrected or not, adds one to the counter in control bits 13:11. Two such reads in one cycle add two. The counter stops at 7.
- R8: Only a control-port write changes the counter downward. A control write in the same cycle as counted errors sets the counter to the written value.
- R9: When the check-disable flag (control bit 0) is 1, reads return their own copy's word raw. No flag is raised and nothing is counted.
- R10: A control write loads bits 13:0 from the write data. Bits 15:14 always read 2'b01.
- R11: A read operand whose enable is low raises no flag and adds nothing to the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd1_en | input | 1 | Operand A read enable |
| rd1_addr | input | 5 | Operand A address |
| rd1_data | output | 32 | Operand A data (combinational) |
| rd1_corr | output | 1 | Operand A corrected-error flag |
| rd1_uncorr | output | 1 | Operand A uncorrectable-error flag |
| rd2_en | input | 1 | Operand B read enable |
| rd2_addr | input | 5 | Operand B address |
| rd2_data | output | 32 | Operand B data (combinational) |
| rd2_corr | output | 1 | Operand B corrected-error flag |
| rd2_uncorr | output | 1 | Operand B uncorrectable-error flag |
| csr_wr | input | 1 | Control word write strobe |
| csr_wdata | input | 16 | Control word write data |
| csr_rdata | output | 16 | Control word readback |

## Verification
Plain writes followed by reads of both operands show that the two copies agree and that reads are clean. Injected writes with copy select 0 and 1 separate the copies. A zero mask tells a stale-but-valid copy apart from a corrupted one. A non-zero mask on one copy drives the correction path and the scrub that follows. The same mask planted on both copies drives the uncorrectable path. Repeated dual-operand error reads push the counter to saturation, and a control write in the same cycle shows that the write wins. Random traffic with narrow address ranges, mixed injection settings and occasional disable then checks every cycle against a bench model of both copies and any pending rewrites.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int DATA_W  = 32;
  localparam int CHK_W   = 8;
  localparam int CNT_W   = 3;
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam logic [1:0] PROT_ID = 2'b01;

  typedef struct packed {
    logic [1:0]       id;
    logic [CNT_W-1:0] cnt;
    logic [CHK_W-1:0] mask;
    logic             sel;
    logic             inj;
    logic             dis;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  // interleaved parity: bit (i mod CHK_W) accumulates data bit i
  function automatic logic [CHK_W-1:0] chk_calc(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] p;
    p = '0;
    for (int i = 0; i < DATA_W; i++) p[i % CHK_W] ^= d[i];
    return p;
  endfunction

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] c,
                                                input logic [1:0] inc);
    logic [CNT_W+1:0] s;
    s = (CNT_W+2)'(c) + (CNT_W+2)'(inc);
    return (s > (CNT_W+2)'(CNT_MAX)) ? CNT_W'(CNT_MAX) : s[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/prf_copy.sv
module prf_copy
  import prf_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CHK_W-1:0]  wchk,
  input  logic [ADDR_W-1:0] ra_own,
  input  logic [ADDR_W-1:0] ra_alt,
  output logic [DATA_W-1:0] own_data,
  output logic              own_ok,
  output logic [DATA_W-1:0] alt_data,
  output logic              alt_ok
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [CHK_W-1:0]  mem_c [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_d[i] <= '0;
        mem_c[i] <= '0;
      end
    end else if (we) begin
      mem_d[waddr] <= wdata;
      mem_c[waddr] <= wchk;
    end
  end

  assign own_data = mem_d[ra_own];
  assign own_ok   = (mem_c[ra_own] == chk_calc(mem_d[ra_own]));
  assign alt_data = mem_d[ra_alt];
  assign alt_ok   = (mem_c[ra_alt] == chk_calc(mem_d[ra_alt]));
endmodule

// File: rtl/prf_ctrl.sv
module prf_ctrl
  import prf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr,
  input  logic [CTL_W-1:0] csr_wdata,
  input  logic [1:0]       err_inc,
  output ctl_t             ctl_q
);
  ctl_t wr_val;

  always_comb begin
    wr_val    = ctl_t'(csr_wdata);
    wr_val.id = PROT_ID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      ctl_q.id <= PROT_ID;
    end else if (csr_wr) begin
      ctl_q <= wr_val;
    end else begin
      ctl_q.cnt <= sat_add(ctl_q.cnt, err_inc);
    end
  end
endmodule

// File: rtl/prf_top.sv
module prf_top
  import prf_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd1_en,
  input  logic [ADDR_W-1:0] rd1_addr,
  output logic [DATA_W-1:0] rd1_data,
  output logic              rd1_corr,
  output logic              rd1_uncorr,
  input  logic              rd2_en,
  input  logic [ADDR_W-1:0] rd2_addr,
  output logic [DATA_W-1:0] rd2_data,
  output logic              rd2_corr,
  output logic              rd2_uncorr,
  input  logic              csr_wr,
  input  logic [CTL_W-1:0]  csr_wdata,
  output logic [CTL_W-1:0]  csr_rdata
);
  localparam int NCOPY = 2;

  ctl_t              ctl_q;
  logic              prot_dis;
  logic [ADDR_W-1:0] rd_addr_a [NCOPY];
  logic              rd_en_a   [NCOPY];
  logic [DATA_W-1:0] own_d     [NCOPY];
  logic [DATA_W-1:0] alt_d     [NCOPY];
  logic              own_ok    [NCOPY];
  logic              alt_ok    [NCOPY];
  logic [DATA_W-1:0] out_d     [NCOPY];
  logic [NCOPY-1:0]  err_det;
  logic [NCOPY-1:0]  fix_ev;
  logic [NCOPY-1:0]  bad_ev;
  logic [NCOPY-1:0]  user_we;
  logic [NCOPY-1:0]  scrub_v;
  logic [ADDR_W-1:0] scrub_a   [NCOPY];
  logic [DATA_W-1:0] scrub_d   [NCOPY];
  logic [1:0]        err_inc;

  assign prot_dis     = ctl_q.dis;
  assign rd_addr_a[0] = rd1_addr;
  assign rd_addr_a[1] = rd2_addr;
  assign rd_en_a[0]   = rd1_en;
  assign rd_en_a[1]   = rd2_en;

  // per-operand check and fallback selection
  always_comb begin
    for (int p = 0; p < NCOPY; p++) begin
      err_det[p] = rd_en_a[p] && !prot_dis && !own_ok[p];
      fix_ev[p]  = err_det[p] && alt_ok[1-p];
      bad_ev[p]  = err_det[p] && !alt_ok[1-p];
      out_d[p]   = fix_ev[p] ? alt_d[1-p] : own_d[p];
    end
  end

  assign err_inc = {1'b0, err_det[0]} + {1'b0, err_det[1]};

  // copy 0 serves operand A (select=1), copy 1 serves operand B (select=0)
  always_comb begin
    for (int c = 0; c < NCOPY; c++)
      user_we[c] = wr_en && (!ctl_q.inj || (ctl_q.sel == (c == 0)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scrub_v <= '0;
      for (int c = 0; c < NCOPY; c++) begin
        scrub_a[c] <= '0;
        scrub_d[c] <= '0;
      end
    end else begin
      scrub_v <= fix_ev;
      for (int c = 0; c < NCOPY; c++) begin
        scrub_a[c] <= rd_addr_a[c];
        scrub_d[c] <= alt_d[1-c];
      end
    end
  end

  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    logic              cp_we;
    logic [ADDR_W-1:0] cp_addr;
    logic [DATA_W-1:0] cp_data;
    logic [CHK_W-1:0]  cp_chk;

    always_comb begin
      cp_we = user_we[c] || scrub_v[c];
      if (user_we[c]) begin
        cp_addr = wr_addr;
        cp_data = wr_data;
        cp_chk  = chk_calc(wr_data) ^ (ctl_q.inj ? ctl_q.mask : '0);
      end else begin
        cp_addr = scrub_a[c];
        cp_data = scrub_d[c];
        cp_chk  = chk_calc(scrub_d[c]);
      end
    end

    prf_copy #(.ADDR_W(ADDR_W)) copy_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cp_we),
      .waddr    (cp_addr),
      .wdata    (cp_data),
      .wchk     (cp_chk),
      .ra_own   (rd_addr_a[c]),
      .ra_alt   (rd_addr_a[1-c]),
      .own_data (own_d[c]),
      .own_ok   (own_ok[c]),
      .alt_data (alt_d[c]),
      .alt_ok   (alt_ok[c])
    );
  end

  prf_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wr    (csr_wr),
    .csr_wdata (csr_wdata),
    .err_inc   (err_inc),
    .ctl_q     (ctl_q)
  );

  assign rd1_data   = out_d[0];
  assign rd2_data   = out_d[1];
  assign rd1_corr   = fix_ev[0];
  assign rd2_corr   = fix_ev[1];
  assign rd1_uncorr = bad_ev[0];
  assign rd2_uncorr = bad_ev[1];
  assign csr_rdata  = ctl_q;
endmodule

// File: rtl/prf_checker.sv
module prf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        prot_dis,
  input logic        rd1_en,
  input logic        rd2_en,
  input logic        rd1_corr,
  input logic        rd1_uncorr,
  input logic        rd2_corr,
  input logic        rd2_uncorr,
  input logic        csr_wr,
  input logic [15:0] csr_wdata,
  input logic [15:0] csr_rdata
);
  // R7: without a control write the counter never goes down
  assert_cnt_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(csr_wr) |-> csr_rdata[13:11] >= $past(csr_rdata[13:11]));

  // R7: at most two counts per cycle
  assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(csr_wr) |-> (4'(csr_rdata[13:11]) <= 4'($past(csr_rdata[13:11])) + 4'd2));

  // R9: disabled checking raises no flag
  assert_no_flag_dis_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prot_dis |-> !(rd1_corr || rd1_uncorr || rd2_corr || rd2_uncorr));

  // R6: corrected and uncorrectable never together on one operand
  assert_excl_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd1_corr && rd1_uncorr) && !(rd2_corr && rd2_uncorr));

  // R11: idle operands never flag
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd1_en |-> !(rd1_corr || rd1_uncorr)) and (!rd2_en |-> !(rd2_corr || rd2_uncorr)));

  // R11: no reads and no control write keep the counter
  assert_idle_cnt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(csr_wr) && !$past(rd1_en) && !$past(rd2_en)) |-> $stable(csr_rdata[13:11]));

  // R10: control write is reflected, id reads 01
  assert_ctl_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(csr_wr) |-> (csr_rdata[13:0] == $past(csr_wdata[13:0])) && (csr_rdata[15:14] == 2'b01));
endmodule

bind prf_top prf_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .prot_dis   (prot_dis),
  .rd1_en     (rd1_en),
  .rd2_en     (rd2_en),
  .rd1_corr   (rd1_corr),
  .rd1_uncorr (rd1_uncorr),
  .rd2_corr   (rd2_corr),
  .rd2_uncorr (rd2_uncorr),
  .csr_wr     (csr_wr),
  .csr_wdata  (csr_wdata),
  .csr_rdata  (csr_rdata)
);

// File: tb/prf_top_tb_top.sv
`timescale 1ns/1ps
module prf_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd1_en = 1'b0, rd2_en = 1'b0;
  logic [4:0]  rd1_addr = '0, rd2_addr = '0;
  logic [31:0] rd1_data, rd2_data;
  logic        rd1_corr, rd1_uncorr, rd2_corr, rd2_uncorr;
  logic        csr_wr = 1'b0;
  logic [15:0] csr_wdata = '0;
  logic [15:0] csr_rdata;

  int n_chk = 0;
  int n_bad = 0;

  // bench model
  logic [31:0] md [2][32];
  logic [7:0]  mc [2][32];
  logic        pv [2];
  logic [4:0]  pa [2];
  logic [31:0] pd [2];
  logic        m_dis, m_inj, m_sel;
  logic [7:0]  m_mask;
  logic [2:0]  m_cnt;

  always #2.5 clk = ~clk;

  prf_top dut_i (.*);

  function automatic logic [7:0] bpar(input logic [31:0] d);
    logic [7:0] r = '0;
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 4; k++) r[j] = r[j] ^ d[k*8 + j];
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      for (int a = 0; a < 32; a++) begin md[c][a] = '0; mc[c][a] = '0; end
      pv[c] = 1'b0; pa[c] = '0; pd[c] = '0;
    end
    m_dis = 0; m_inj = 0; m_sel = 0; m_mask = '0; m_cnt = '0;
  endtask

  // inputs set at negedge; compare, then advance model across the edge
  task automatic step(input string tag);
    logic [4:0]  ra [2];
    logic        re [2];
    logic [31:0] gd [2];
    logic        gc [2], gu [2];
    logic        nv [2];
    logic [4:0]  na [2];
    logic [31:0] nd [2];
    int inc;
    #1;
    ra[0] = rd1_addr; ra[1] = rd2_addr; re[0] = rd1_en; re[1] = rd2_en;
    gd[0] = rd1_data; gd[1] = rd2_data;
    gc[0] = rd1_corr; gc[1] = rd2_corr; gu[0] = rd1_uncorr; gu[1] = rd2_uncorr;
    inc = 0;
    for (int p = 0; p < 2; p++) begin
      logic own_good, alt_good, err;
      logic [31:0] ed;
      own_good = (mc[p][ra[p]] == bpar(md[p][ra[p]]));
      alt_good = (mc[1-p][ra[p]] == bpar(md[1-p][ra[p]]));
      err = re[p] && !m_dis && !own_good;
      ed  = (err && alt_good) ? md[1-p][ra[p]] : md[p][ra[p]];
      nv[p] = err && alt_good; na[p] = ra[p]; nd[p] = md[1-p][ra[p]];
      if (err) inc++;
      if (re[p]) chk(tag, p == 0 ? "rdA data" : "rdB data", gd[p], ed);
      chk(tag, p == 0 ? "rdA corr" : "rdB corr", 32'(gc[p]), 32'(err && alt_good));
      chk(tag, p == 0 ? "rdA uncorr" : "rdB uncorr", 32'(gu[p]), 32'(err && !alt_good));
    end
    chk(tag, "ctl word", 32'(csr_rdata), 32'({2'b01, m_cnt, m_mask, m_sel, m_inj, m_dis}));
    for (int c = 0; c < 2; c++) begin
      logic uw;
      uw = wr_en && (!m_inj || (m_sel == (c == 0)));
      if (uw) begin
        md[c][wr_addr] = wr_data;
        mc[c][wr_addr] = bpar(wr_data) ^ (m_inj ? m_mask : 8'h00);
      end else if (pv[c]) begin
        md[c][pa[c]] = pd[c];
        mc[c][pa[c]] = bpar(pd[c]);
      end
    end
    for (int c = 0; c < 2; c++) begin pv[c] = nv[c]; pa[c] = na[c]; pd[c] = nd[c]; end
    if (csr_wr) begin
      m_dis = csr_wdata[0]; m_inj = csr_wdata[1]; m_sel = csr_wdata[2];
      m_mask = csr_wdata[10:3]; m_cnt = csr_wdata[13:11];
    end else begin
      m_cnt = (int'(m_cnt) + inc > 7) ? 3'd7 : 3'(int'(m_cnt) + inc);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; rd1_en = 0; rd2_en = 0; csr_wr = 0;
  endtask

  function automatic logic [15:0] ctl(input logic [2:0] cnt, input logic [7:0] mask,
                                      input logic sel, input logic inj, input logic dis);
    return {2'b00, cnt, mask, sel, inj, dis};
  endfunction

  task automatic set_ctl(input logic [15:0] v, input string tag);
    idle(); csr_wr = 1; csr_wdata = v; step(tag); csr_wr = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
    idle(); wr_en = 1; wr_addr = a; wr_data = d; step(tag); wr_en = 0;
  endtask

  task automatic rd(input logic e1, input logic [4:0] a1, input logic e2, input logic [4:0] a2,
                    input string tag);
    idle(); rd1_en = e1; rd1_addr = a1; rd2_en = e2; rd2_addr = a2; step(tag);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL R2 watchdog got=running exp=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd(1, 5'd0, 1, 5'd31, "R1");
    // R2: plain writes reach both copies
    for (int a = 0; a < 32; a++) wr(5'(a), $urandom, "R2");
    for (int i = 0; i < 16; i++) rd(1, 5'($urandom), 1, 5'($urandom), "R2");
    // R4 / R3: inject into operand-B copy only, non-zero mask
    set_ctl(ctl(3'd0, 8'h01, 1'b0, 1'b1, 1'b0), "R10");
    wr(5'd3, 32'hA5A5_0F0F, "R4");
    rd(1, 5'd3, 0, 5'd0, "R4");
    rd(0, 5'd0, 1, 5'd3, "R5");
    rd(0, 5'd0, 0, 5'd0, "R5");
    rd(1, 5'd3, 1, 5'd3, "R5");
    // R4 / R3: operand-A copy only, zero mask stores valid bits
    set_ctl(ctl(3'd0, 8'h00, 1'b1, 1'b1, 1'b0), "R10");
    wr(5'd4, 32'h1234_5678, "R3");
    rd(1, 5'd4, 1, 5'd4, "R4");
    // R6: same mask on both copies
    set_ctl(ctl(3'd0, 8'h80, 1'b0, 1'b1, 1'b0), "R10");
    wr(5'd5, 32'hDEAD_BEEF, "R6");
    set_ctl(ctl(3'd0, 8'h80, 1'b1, 1'b1, 1'b0), "R10");
    wr(5'd5, 32'hCAFE_F00D, "R6");
    set_ctl(ctl(3'd0, 8'h00, 1'b0, 1'b0, 1'b0), "R10");
    rd(1, 5'd5, 0, 5'd0, "R6");
    // R7: dual errors per cycle until saturation
    for (int i = 0; i < 5; i++) rd(1, 5'd5, 1, 5'd5, "R7");
    // R8: control write wins over counted errors
    idle(); rd1_en = 1; rd1_addr = 5'd5; rd2_en = 1; rd2_addr = 5'd5;
    csr_wr = 1; csr_wdata = ctl(3'd1, 8'h00, 1'b0, 1'b0, 1'b0); step("R8");
    rd(0, 5'd0, 0, 5'd0, "R8");
    // R11: disabled operands at a bad address
    rd(0, 5'd5, 0, 5'd5, "R11");
    rd(0, 5'd5, 0, 5'd5, "R11");
    // R9: checking off
    set_ctl(ctl(3'd2, 8'h00, 1'b0, 1'b0, 1'b1), "R10");
    rd(1, 5'd5, 1, 5'd5, "R9");
    rd(1, 5'd3, 1, 5'd5, "R9");
    // R4: select ignored when injection is off
    set_ctl(ctl(3'd0, 8'hFF, 1'b1, 1'b0, 1'b0), "R10");
    wr(5'd5, 32'h0BAD_F00D, "R4");
    rd(1, 5'd5, 1, 5'd5, "R4");
    // random phase against the model
    for (int i = 0; i < 600; i++) begin
      idle();
      wr_en = ($urandom % 2) == 0;
      wr_addr = 5'($urandom % 8); wr_data = $urandom;
      rd1_en = ($urandom % 3) != 0; rd1_addr = 5'($urandom % 8);
      rd2_en = ($urandom % 3) != 0; rd2_addr = 5'($urandom % 8);
      if (($urandom % 12) == 0) begin
        csr_wr = 1;
        csr_wdata = ctl(3'($urandom), 8'($urandom), 1'($urandom),
                        ($urandom % 3) == 0, ($urandom % 8) == 0);
      end
      step("R5");
    end
    idle();
    finish_run();
  end
endmodule